// File: doc/BRIEF.md
# Sixteen-bit Timer/Counter with Synchronous and Asynchronous Event Counting

This block keeps a 16-bit count that software reaches through two byte-wide registers, one for the lower byte and one for the upper. The count advances on one of three sources. In timer mode it advances on every cycle of the internal clock. In synchronous counter mode it advances on rising edges of an external input that pass through a two-stage synchronizer. In asynchronous counter mode it advances on rising edges seen after a single capture stage, which gives lower latency. A control register holds an enable, a clock-source select and a synchronizer bypass. It also shows a read-only status bit. That bit tells whether the device clock is running from this timer's oscillator.

When the count wraps from all ones to zero, a sticky interrupt flag is set. Software clears it by writing a one. A one-cycle pulse on the special-event trigger input returns the count to zero. The trigger takes priority over register writes and over counting. Reading the lower byte captures the upper byte into a holding register, and later reads of the upper byte return that copy. This keeps a 16-bit read consistent while the count is running.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the count, the control register, the holding register and the overflow flag are all zero, and `ovf_irq` is low.
- R2: With enable (control bit 0) set and clock select (control bit 1) clear, the count rises by one on every clock edge.
- R3: With enable clear, the count keeps its value whatever happens on the external input.
- R4: With enable and clock select set and bypass (control bit 2) clear, a rising edge of `ext_clk_in` that is first sampled at clock edge k raises the count by one at edge k+2.
- R5: With enable, clock select and bypass all set, a rising edge of `ext_clk_in` that is first sampled at edge k raises the count by one at edge k+1.
- R6: In external mode, a falling edge or a steady level on `ext_clk_in` does not change the count, and the internal clock does not advance it.
- R7: When the count steps from 0xFFFF to 0x0000, the flag (bit 0 of address 3) is set, and `ovf_irq` follows it. The flag stays set until a write to address 3 with data bit 0 set. A write with bit 0 clear has no effect. If a wrap and a clearing write fall in the same cycle, the flag ends set.
- R8: `evt_trig` high at a clock edge makes the count zero at that edge. It wins over a register write and over a step in the same cycle, and a wrap suppressed this way does not set the flag.
- R9: A write to address 0 replaces the lower byte and a write to address 1 replaces the upper byte. In the cycle of such a write, the write wins over counting.
- R10: A read of address 0 returns the lower byte and copies the current upper byte into the holding register. A read of address 1 returns the holding register.
- R11: Control bit 6 reads as the level of `osc_status_in`, and writes to it are ignored.
- R12: The control register at address 2 keeps bits 0 to 2 as written, and its other bits (except bit 6) read as zero. `rd_data` is zero when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_in | input | 1 | External count input |
| evt_trig | input | 1 | Special-event pulse that zeroes the count |
| osc_status_in | input | 1 | High while the device clock comes from this timer's oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low byte, 1 high byte, 2 control, 3 flag |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data, combinational from the address |
| ovf_irq | output | 1 | Sticky overflow interrupt flag |

## Verification
Two collisions are provoked. In the first, the count is preloaded to 0xFFFF and the timer is enabled, so the wrap lands on a known edge. `evt_trig` is raised for exactly that edge. The bench then expects a count of zero and `ovf_irq` still low. In the second, a write that clears the flag is placed on the wrap edge, and the flag must end set. Both results are judged only through `ovf_irq` and register reads taken after the colliding edge.

// File: rtl/tmr16_pkg.sv
// Package: shared widths, register addresses and control bit positions
// for the 16-bit timer/counter. Assumes a byte-wide register port.
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG   = 2'd3;

    localparam int BIT_EN    = 0;
    localparam int BIT_EXT   = 1;
    localparam int BIT_ASYNC = 2;
    localparam int BIT_OSC   = 6;
    localparam int BIT_CLR   = 0;
endpackage

// File: rtl/tmr16_edge.sv
// Module: external input sampler and rising-edge detector.
// Assumes STAGES >= 2. The synchronous tick comes from the last stage,
// the asynchronous tick from the first stage, one cycle earlier.
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic async_sel,
    output logic tick
);
    logic [STAGES-1:0] samp_q;
    logic              last_q;
    logic              tick_sync;
    logic              tick_fast;

    // Shift the external level through the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            last_q <= 1'b0;
        end else begin
            samp_q <= {samp_q[STAGES-2:0], ext_in};
            last_q <= samp_q[STAGES-1];
        end
    end

    // Rising edge detection on both taps, then pick the one the mode asks for.
    always_comb begin
        tick_sync = samp_q[STAGES-1] & ~last_q;
        tick_fast = samp_q[0] & ~samp_q[1];
        tick      = async_sel ? tick_fast : tick_sync;
    end

    // R6: one rising edge yields a single tick unless the mode changed.
    a_r6_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || (async_sel != $past(async_sel))));
endmodule

// File: rtl/tmr16_core.sv
// Module: 16-bit counting register with trigger, byte writes and wrap detect.
// Priority at each edge: trigger, then byte write, then step.
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ext_sel,
    input  logic              ext_tick,
    input  logic              trig,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_hit
);
    logic             step;
    logic             wr_any;
    logic [CNT_W-1:0] cnt_nxt;

    // Work out the next count from the priority order.
    always_comb begin
        step    = enable & (ext_sel ? ext_tick : 1'b1);
        wr_any  = wr_lo | wr_hi;
        cnt_nxt = count;
        if (trig) begin
            cnt_nxt = '0;
        end else if (wr_any) begin
            if (wr_lo) cnt_nxt[BYTE_W-1:0]     = wr_byte;
            if (wr_hi) cnt_nxt[CNT_W-1:BYTE_W] = wr_byte;
        end else if (step) begin
            cnt_nxt = count + 1'b1;
        end
        ovf_hit = step & ~trig & ~wr_any & (&count);
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= cnt_nxt;
    end

    // R8: the trigger zeroes the count at its edge.
    a_r8_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == '0));
    // R3: a disabled counter with no write or trigger holds its value.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !trig && !wr_lo && !wr_hi) |=> (count == $past(count)));
    // R2: timer mode advances by one per clock.
    a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !ext_sel && !trig && !wr_lo && !wr_hi)
            |=> (count == CNT_W'($past(count) + 1'b1)));
    // R7: a wrap leaves the count at zero.
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> (count == '0));
    // R9: a low-byte write lands unless a trigger overrides it.
    a_r9_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !trig) |=> (count[BYTE_W-1:0] == $past(wr_byte)));
endmodule

// File: rtl/tmr16_regs.sv
// Module: register file for control bits, overflow flag and the
// upper-byte holding register, plus the combinational read mux.
module tmr16_regs
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              osc_status,
    input  logic              ovf_hit,
    output logic [BYTE_W-1:0] rd_data,
    output logic              enable,
    output logic              ext_sel,
    output logic              async_sel,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              ovf_flag
);
    logic              wr_ctrl;
    logic              flag_clr;
    logic              rd_lo;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] ctrl_view;
    logic [BYTE_W-1:0] flag_view;

    // Decode writes and reads.
    always_comb begin
        wr_lo    = wr_en && (wr_addr == ADR_CNT_LO);
        wr_hi    = wr_en && (wr_addr == ADR_CNT_HI);
        wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
        flag_clr = wr_en && (wr_addr == ADR_FLAG) && wr_data[BIT_CLR];
        rd_lo    = rd_en && (rd_addr == ADR_CNT_LO);
        wr_byte  = wr_data;
    end

    // Store the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            ext_sel   <= 1'b0;
            async_sel <= 1'b0;
        end else if (wr_ctrl) begin
            enable    <= wr_data[BIT_EN];
            ext_sel   <= wr_data[BIT_EXT];
            async_sel <= wr_data[BIT_ASYNC];
        end
    end

    // Sticky overflow flag; a wrap wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (ovf_hit)  ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    // Capture the upper byte when the lower byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= '0;
        else if (rd_lo) hold_q <= count[CNT_W-1:BYTE_W];
    end

    // Assemble the read views and select by address.
    always_comb begin
        ctrl_view            = '0;
        ctrl_view[BIT_EN]    = enable;
        ctrl_view[BIT_EXT]   = ext_sel;
        ctrl_view[BIT_ASYNC] = async_sel;
        ctrl_view[BIT_OSC]   = osc_status;
        flag_view            = '0;
        flag_view[BIT_CLR]   = ovf_flag;
        rd_data              = '0;
        if (rd_en) begin
            case (rd_addr)
                ADR_CNT_LO: rd_data = count[BYTE_W-1:0];
                ADR_CNT_HI: rd_data = hold_q;
                ADR_CTRL:   rd_data = ctrl_view;
                default:    rd_data = flag_view;
            endcase
        end
    end

    // R7: the flag stays set until a clearing write.
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    // R7: a wrap always leaves the flag set, even against a clear.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> ovf_flag);
    // R10: the holding register changes only on a low-byte read.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(hold_q));
    // R12: a control write stores the enable bit.
    a_r12_ctrl_en: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (enable == $past(wr_data[BIT_EN])));
endmodule

// File: rtl/tmr16_unit.sv
// Module: top of the 16-bit timer/counter. Joins the edge sampler,
// the counting core and the register file. One clock domain; the
// external input is treated as asynchronous to it.
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_in,
    input  logic              evt_trig,
    input  logic              osc_status_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_irq
);
    logic              enable;
    logic              ext_sel;
    logic              async_sel;
    logic              ext_tick;
    logic              wr_lo;
    logic              wr_hi;
    logic [BYTE_W-1:0] wr_byte;
    logic [CNT_W-1:0]  count;
    logic              ovf_hit;

    tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_clk_in),
        .async_sel (async_sel),
        .tick      (ext_tick)
    );

    tmr16_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .ext_sel  (ext_sel),
        .ext_tick (ext_tick),
        .trig     (evt_trig),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_byte  (wr_byte),
        .count    (count),
        .ovf_hit  (ovf_hit)
    );

    tmr16_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .count      (count),
        .osc_status (osc_status_in),
        .ovf_hit    (ovf_hit),
        .rd_data    (rd_data),
        .enable     (enable),
        .ext_sel    (ext_sel),
        .async_sel  (async_sel),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_byte    (wr_byte),
        .ovf_flag   (ovf_irq)
    );

    // R1: the interrupt output is low in the first cycle after reset.
    a_r1_irq_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !ovf_irq);
endmodule

// File: tb/tmr16_unit_tb.sv
`timescale 1ns/1ps
module tmr16_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       evt_trig = 1'b0;
    logic       osc_status_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_irq;

    int total = 0;
    int bad   = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    tmr16_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .evt_trig(evt_trig),
        .osc_status_in(osc_status_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_irq(ovf_irq)
    );

    typedef struct packed {
        logic       rd;
        logic [1:0] adr;
        logic [7:0] val;
    } step_t;

    localparam int NV = 12;
    localparam step_t TBL [NV] = '{
        '{1'b0, 2'd0, 8'h34}, '{1'b0, 2'd1, 8'h12},
        '{1'b1, 2'd0, 8'h34}, '{1'b1, 2'd1, 8'h12},
        '{1'b0, 2'd0, 8'hAB}, '{1'b1, 2'd0, 8'hAB},
        '{1'b1, 2'd1, 8'h12}, '{1'b1, 2'd2, 8'h00},
        '{1'b0, 2'd2, 8'hFF}, '{1'b1, 2'd2, 8'h07},
        '{1'b0, 2'd2, 8'h00}, '{1'b1, 2'd2, 8'h00}
    };

    // All tasks start and end on a falling edge.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq", {7'd0, ovf_irq}, 8'h00);
        rd(2'd0, got); check("R1 lo", got, 8'h00);
        rd(2'd1, got); check("R1 hi", got, 8'h00);
        rd(2'd2, got); check("R1 ctrl", got, 8'h00);
        rd(2'd3, got); check("R1 flag", got, 8'h00);

        // Table walk: R9 byte writes, R10 holding reads, R12 control layout
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].rd) begin
                rd(TBL[i].adr, got);
                check(TBL[i].adr == 2'd2 ? "R12 table" : "R9/R10 table", got, TBL[i].val);
            end else begin
                wr(TBL[i].adr, TBL[i].val);
            end
        end

        // R10: holding register keeps the byte captured at the low read
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        rd(2'd0, got);
        wr(2'd1, 8'h56);
        rd(2'd1, got); check("R10 stale hold", got, 8'h12);
        rd(2'd0, got);
        rd(2'd1, got); check("R10 fresh hold", got, 8'h56);

        // R2: timer mode, 21 steps from 0x0010
        wr(2'd0, 8'h10); wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        repeat (20) @(negedge clk);
        wr(2'd2, 8'h00);
        rd(2'd0, got); check("R2 timer steps", got, 8'h25);
        // R3: disabled counter holds
        ext_clk_in = 1'b1;
        repeat (10) @(negedge clk);
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, got); check("R3 hold", got, 8'h25);

        // R9: write wins over a step in the same cycle
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h80);
        wr(2'd2, 8'h00);
        rd(2'd0, got); check("R9 write over step", got, 8'h81);

        // R7: wrap sets the sticky flag
        wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        @(negedge clk); check("R7 before wrap", {7'd0, ovf_irq}, 8'h00);
        @(negedge clk); check("R7 after wrap", {7'd0, ovf_irq}, 8'h01);
        wr(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        check("R7 sticky", {7'd0, ovf_irq}, 8'h01);
        rd(2'd3, got); check("R7 flag read", got, 8'h01);
        wr(2'd3, 8'h00); check("R7 zero write", {7'd0, ovf_irq}, 8'h01);
        wr(2'd3, 8'h01); check("R7 clear", {7'd0, ovf_irq}, 8'h00);
        rd(2'd0, got); check("R7 wrapped count", got, 8'h01);

        // R7: wrap and clear in the same cycle, flag ends set
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h01);
        check("R7 set wins", {7'd0, ovf_irq}, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        check("R7 cleared again", {7'd0, ovf_irq}, 8'h00);

        // R8: trigger zeroes a held count
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd(2'd0, got); check("R8 trig lo", got, 8'h00);
        rd(2'd1, got); check("R8 trig hi", got, 8'h00);
        // R8: trigger beats a write in the same cycle
        evt_trig = 1'b1; wr(2'd0, 8'h55); evt_trig = 1'b0;
        rd(2'd0, got); check("R8 trig over write", got, 8'h00);
        // R8: trigger on the wrap edge suppresses the flag
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        wr(2'd2, 8'h01);
        evt_trig = 1'b1; wr(2'd2, 8'h00); evt_trig = 1'b0;
        check("R8 no flag", {7'd0, ovf_irq}, 8'h00);
        rd(2'd0, got); check("R8 collide lo", got, 8'h00);
        rd(2'd1, got); check("R8 collide hi", got, 8'h00);

        // R4: synchronous external counting, two-edge delay
        wr(2'd2, 8'h03);
        repeat (3) @(negedge clk);
        ext_clk_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(2'd0, got); check("R4 not yet", got, 8'h00);
        rd(2'd0, got); check("R4 counted", got, 8'h01);
        // R6: falling edge and steady level do not count
        ext_clk_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, got); check("R6 no count", got, 8'h01);
        ext_clk_in = 1'b1; @(negedge clk); ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, got); check("R4 short pulse", got, 8'h02);

        // R5: asynchronous external counting, one-edge delay
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h07);
        repeat (3) @(negedge clk);
        ext_clk_in = 1'b1;
        @(negedge clk);
        rd(2'd0, got); check("R5 not yet", got, 8'h00);
        rd(2'd0, got); check("R5 counted", got, 8'h01);
        ext_clk_in = 1'b0;
        wr(2'd2, 8'h00);

        // R11: clock status bit follows the input, ignores writes
        osc_status_in = 1'b1;
        #1;
        rd(2'd2, got); check("R11 status high", got, 8'h40);
        osc_status_in = 1'b0;
        wr(2'd2, 8'h40);
        rd(2'd2, got); check("R11 write ignored", got, 8'h00);
        // R12: idle read port returns zero
        #1 check("R12 idle read", rd_data, 8'h00);

        summary();
    end
endmodule